// File: doc/BRIEF.md
# Converter Control and Status Register

This block is the 16-bit control and status word for one analog-to-digital converter channel group. It sits on a simple single-register bus with a select strobe, a write strobe and two byte enables. It holds the fields that steer the converter: channel number, operating mode, clock choice, trigger enable, start timing, cycle choice and continuation control. It also holds a sticky end-of-conversion flag, which raises an interrupt request when the interrupt enable is set.

The converter sequencer reports each finished conversion with a one-cycle strobe, and marks the strobe that ends the last selected channel. In single mode every completion sets the flag. In any scan mode only the completion of the final channel sets it. Software clears the flag with a handshake: it must first read the register and see the flag at 1, and then write 0 to it. A direct-memory-access read of the result register, started by the interrupt, also clears the flag. So does a transfer-controller read, unless that transfer asks to keep the flag.

The whole register image is driven out continuously so the converter logic can decode its fields.

Top module: `adc_ctlstat_reg`

## Requirements
- R1: After a synchronous active-low reset, every register bit, the read data and the interrupt request are 0.
- R2: Writable bits are 14 (interrupt enable), 11 (trigger enable), 9 (continuation), 8 (start timing), 7:6 (clock select), 5:4 (mode), 3 (cycle select) and 2:0 (channel). Byte enable 1 gates bits 15:8 and byte enable 0 gates bits 7:0, each independently of the other.
- R3: Bits 13, 12 and 10 always read 0, whatever is written to them.
- R4: When the mode field (bits 5:4) is 00 (single), every conversion-end strobe sets the flag (bit 15).
- R5: When the mode field is 01, 10 or 11 (scan), a conversion-end strobe sets the flag only if the last-channel marker is high in that same cycle.
- R6: Writing 1 to bit 15 never changes the flag. Writing 0 to bit 15 with no earlier read that returned the flag as 1 leaves the flag unchanged.
- R7: A write with byte enable 1 high and bit 15 = 0 clears the flag when an earlier read returned it as 1. Any write with byte enable 1 high ends that read permission. A write with only byte enable 0 high neither clears the flag nor ends the permission.
- R8: A DMA result-read acknowledge clears the flag.
- R9: A transfer-controller result-read acknowledge clears the flag only when the keep input is 0 in the same cycle.
- R10: When a set strobe and any clear cause occur in the same cycle, the flag ends up at 1.
- R11: The interrupt request is high exactly while both the flag and bit 14 are 1.
- R12: Read data appears on the clock edge after the read request and holds the register contents from before that edge. It keeps that value until the next read.
- R13: Read permission is lost whenever the flag clears by any path. After that, a later set followed by a write of 0 without a fresh read leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 2 | Byte enables, bit 1 = upper byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| conv_end | input | 1 | One-cycle conversion completion strobe |
| conv_last | input | 1 | Marks completion of the final selected channel |
| dma_rd_ack | input | 1 | DMA read of the result register |
| xfer_rd_ack | input | 1 | Transfer-controller read of the result register |
| xfer_keep | input | 1 | Transfer asks the flag to be left set |
| csr_image | output | 16 | Live register contents for field decoding |
| end_irq | output | 1 | End-of-conversion interrupt request |

## Verification
The hardest state to reach from the ports is read permission that has gone stale. The flag is read as 1, then cleared by a DMA acknowledge, then set again by a new conversion, and then software writes 0 without reading again. The bench builds exactly this sequence, and checks that the flag survives the write. It also covers the variants where the permission is used up by a write of 1, or is kept alive through a lower-byte-only write. Same-cycle collisions between a set strobe and each clear path are driven in a single cycle.

// File: rtl/adc_csr_pkg.sv
// Package: shared widths, bit positions and masks of the control/status word.
// Assumes a 16-bit register split into two byte lanes.
package adc_csr_pkg;
    localparam int REG_W     = 16;
    localparam int LANE_W    = 8;
    localparam int LANES     = REG_W / LANE_W;
    localparam int FLAG_BIT  = 15;
    localparam int IE_BIT    = 14;
    localparam int MODE_LSB  = 4;
    localparam int MODE_W    = 2;
    // writable control bits: 14, 11, 9, 8 and 7:0
    localparam logic [REG_W-1:0] CTL_MASK = 16'h4BFF;
    localparam logic [MODE_W-1:0] MODE_SINGLE = 2'b00;
endpackage

// File: rtl/adc_csr_ctl.sv
// Byte-laned storage for the writable control fields.
// Assumes wr_en is a single-cycle qualified write; bits outside MASK stay 0.
module adc_csr_ctl #(
    parameter int W      = 16,
    parameter int LW     = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [W/LW-1:0] be,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    q
);
    localparam int NL = W / LW;

    for (genvar b = 0; b < NL; b++) begin : g_lane
        // one lane: load masked write data when its byte enable is set
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[b*LW +: LW] <= '0;
            else if (wr_en && be[b])
                q[b*LW +: LW] <= wdata[b*LW +: LW] & MASK[b*LW +: LW];
        end
    end

    // R2
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
    // R3
    ctl_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~MASK) == '0);
endmodule

// File: rtl/adc_csr_evt.sv
// Qualifies conversion-end strobes by mode: single mode takes every strobe,
// scan modes take only the strobe that ends the last channel.
module adc_csr_evt #(
    parameter int MW = 2,
    parameter logic [MW-1:0] SINGLE = '0
) (
    input  logic          conv_end,
    input  logic          conv_last,
    input  logic [MW-1:0] mode,
    output logic          set_evt
);
    // decide whether this completion ends the programmed work
    always_comb begin
        set_evt = conv_end && ((mode == SINGLE) || conv_last);
    end
endmodule

// File: rtl/adc_csr_flag.sv
// Sticky end flag with read-then-write-zero clear and transfer-driven clears.
// Assumes rd_req and wr_hi are never high in the same cycle.
module adc_csr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic dma_ack,
    input  logic xfer_ack,
    input  logic xfer_keep,
    input  logic rd_req,
    input  logic wr_hi,
    input  logic wr_bit,
    output logic flag
);
    logic seen_q, seen_d, flag_d, clr_sw, clr_any;

    // gather every clear cause of this cycle
    always_comb begin
        clr_sw  = wr_hi && !wr_bit && seen_q;
        clr_any = dma_ack || (xfer_ack && !xfer_keep) || clr_sw;
    end

    // next flag: set has priority; next permission dies with the flag or an upper write
    always_comb begin
        flag_d = set_evt ? 1'b1 : (clr_any ? 1'b0 : flag);
        if (!flag_d || wr_hi)
            seen_d = 1'b0;
        else if (rd_req && flag)
            seen_d = 1'b1;
        else
            seen_d = seen_q;
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            flag   <= flag_d;
            seen_q <= seen_d;
        end
    end

    // R13
    seen_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> flag);
    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_evt));
    // R7
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(dma_ack || (xfer_ack && !xfer_keep) || (wr_hi && !wr_bit && seen_q)));
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
endmodule

// File: rtl/adc_ctlstat_reg.sv
// Top: converter control/status register on a single-word bus.
// Assumes one access per request cycle; reads return data on the next edge.
module adc_ctlstat_reg
    import adc_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              conv_end,
    input  logic              conv_last,
    input  logic              dma_rd_ack,
    input  logic              xfer_rd_ack,
    input  logic              xfer_keep,
    output logic [REG_W-1:0]  csr_image,
    output logic              end_irq
);
    logic              wr_en, rd_req, wr_hi, set_evt, flag;
    logic [REG_W-1:0]  ctl_q;

    // decode bus strobes
    always_comb begin
        wr_en  = bus_sel && bus_wr;
        rd_req = bus_sel && !bus_wr;
        wr_hi  = wr_en && bus_be[LANES-1];
    end

    adc_csr_ctl #(.W(REG_W), .LW(LANE_W), .MASK(CTL_MASK)) i_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .be(bus_be),
        .wdata(bus_wdata), .q(ctl_q)
    );

    adc_csr_evt #(.MW(MODE_W), .SINGLE(MODE_SINGLE)) i_evt (
        .conv_end(conv_end), .conv_last(conv_last),
        .mode(ctl_q[MODE_LSB +: MODE_W]), .set_evt(set_evt)
    );

    adc_csr_flag i_flag (
        .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .dma_ack(dma_rd_ack),
        .xfer_ack(xfer_rd_ack), .xfer_keep(xfer_keep), .rd_req(rd_req),
        .wr_hi(wr_hi), .wr_bit(bus_wdata[FLAG_BIT]), .flag(flag)
    );

    // assemble the visible word and the interrupt request
    always_comb begin
        csr_image = ctl_q | (REG_W'(flag) << FLAG_BIT);
        end_irq   = flag && ctl_q[IE_BIT];
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_req)
            bus_rdata <= csr_image;
    end

    // R12
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rdata == $past(csr_image));
    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata));
endmodule

// File: tb/test_adc_ctlstat_reg.sv
module test_adc_ctlstat_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [1:0]  bus_be = 0;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata, csr_image;
    logic        conv_end = 0, conv_last = 0, dma_rd_ack = 0;
    logic        xfer_rd_ack = 0, xfer_keep = 0, end_irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [15:0] ctl_m;
    logic [15:0] rv;

    always #2 clk = ~clk;

    adc_ctlstat_reg i_adc_ctlstat_reg (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_end(conv_end), .conv_last(conv_last), .dma_rd_ack(dma_rd_ack),
        .xfer_rd_ack(xfer_rd_ack), .xfer_keep(xfer_keep),
        .csr_image(csr_image), .end_irq(end_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_be = 0;
        ctl_m = (ctl_m & ~(be[1] ? 16'h4B00 : 16'h0) & ~(be[0] ? 16'h00FF : 16'h0))
              | (d & (be[1] ? 16'h4B00 : 16'h0)) | (d & (be[0] ? 16'h00FF : 16'h0));
    endtask

    task automatic rd(output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic pulse_conv(input logic last);
        @(negedge clk);
        conv_end = 1; conv_last = last;
        @(negedge clk);
        conv_end = 0; conv_last = 0;
    endtask

    task automatic pulse_dma();
        @(negedge clk); dma_rd_ack = 1;
        @(negedge clk); dma_rd_ack = 0;
    endtask

    // writes control fields with flag bit 0 in the upper lane
    task automatic set_ctl(input logic [15:0] c);
        wr(c & 16'h7FFF, 2'b11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        ctl_m = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 image", csr_image, 16'h0);
        chk("R1 rdata", bus_rdata, 16'h0);
        chk("R1 irq", {15'h0, end_irq}, 16'h0);

        // R2 R3 sweep of write patterns and byte enables
        for (int i = 0; i < 256; i++) begin
            logic [15:0] d;
            d = {i[7:0], ~i[7:0]} ^ {8'h00, i[3:0], i[7:4]};
            wr(d, i[1:0] ^ i[5:4]);
            rd(rv);
            chk("R2/R3 sweep read", rv, ctl_m);
            chk("R3 reserved", rv & 16'h3400, 16'h0);
        end

        // R4 R5 mode vs last marker sweep
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 2; l++) begin
                set_ctl(16'h4000 | 16'(m << 4));
                pulse_dma();
                pulse_conv(l[0]);
                rd(rv);
                chk((m == 0) ? "R4 single set" : "R5 scan set",
                    {15'h0, rv[15]}, {15'h0, (m == 0) || (l == 1)});
                chk("R11 irq", {15'h0, end_irq}, {15'h0, (m == 0) || (l == 1)});
            end
        end
        pulse_dma();

        // R11 ie off
        set_ctl(16'h0000);
        pulse_conv(0);
        chk("R11 irq masked", {15'h0, end_irq}, 16'h0);
        set_ctl(16'h4000);
        chk("R11 irq on", {15'h0, end_irq}, 16'h1);
        pulse_dma();
        chk("R8 dma clears", {15'h0, csr_image[15]}, 16'h0);

        // R6 write 0 without read
        pulse_conv(0);
        wr(16'h4000, 2'b10);
        chk("R6 no read", {15'h0, csr_image[15]}, 16'h1);
        // R6 write 1 after read: no change, and permission used up
        rd(rv);
        wr(16'hC000, 2'b10);
        chk("R6 write one", {15'h0, csr_image[15]}, 16'h1);
        wr(16'h4000, 2'b10);
        chk("R7 permission spent", {15'h0, csr_image[15]}, 16'h1);
        // R7 lower-only write keeps permission
        rd(rv);
        chk("R7 read shows flag", {15'h0, rv[15]}, 16'h1);
        wr(16'h0000, 2'b01);
        chk("R7 lower only", {15'h0, csr_image[15]}, 16'h1);
        wr(16'h4000, 2'b10);
        chk("R7 handshake clear", {15'h0, csr_image[15]}, 16'h0);
        chk("R11 irq drops", {15'h0, end_irq}, 16'h0);

        // R13 stale permission
        pulse_conv(0);
        rd(rv);
        pulse_dma();
        pulse_conv(0);
        wr(16'h4000, 2'b10);
        chk("R13 stale permission", {15'h0, csr_image[15]}, 16'h1);

        // R9 transfer controller clears
        @(negedge clk); xfer_rd_ack = 1; xfer_keep = 1;
        @(negedge clk); xfer_rd_ack = 0; xfer_keep = 0;
        chk("R9 keep set", {15'h0, csr_image[15]}, 16'h1);
        @(negedge clk); xfer_rd_ack = 1;
        @(negedge clk); xfer_rd_ack = 0;
        chk("R9 keep clear", {15'h0, csr_image[15]}, 16'h0);

        // R10 set vs dma in same cycle
        @(negedge clk); conv_end = 1; dma_rd_ack = 1;
        @(negedge clk); conv_end = 0; dma_rd_ack = 0;
        chk("R10 set vs dma", {15'h0, csr_image[15]}, 16'h1);
        // R10 set vs software clear in same cycle
        rd(rv);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_be = 2'b10; bus_wdata = 16'h4000; conv_end = 1;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_be = 0; conv_end = 0;
        chk("R10 set vs write", {15'h0, csr_image[15]}, 16'h1);
        @(negedge clk); conv_end = 1; xfer_rd_ack = 1;
        @(negedge clk); conv_end = 0; xfer_rd_ack = 0;
        chk("R10 set vs xfer", {15'h0, csr_image[15]}, 16'h1);
        pulse_dma();

        // R12 latency and hold
        set_ctl(16'h4015);
        rd(rv);
        chk("R12 first read", rv, 16'h4015);
        set_ctl(16'h0A2C);
        chk("R12 holds", bus_rdata, 16'h4015);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0;
        #1 chk("R12 before edge", bus_rdata, 16'h4015);
        @(negedge clk);
        bus_sel = 0;
        chk("R12 after edge", bus_rdata, 16'h0A2C);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule